// File: doc/BRIEF.md
# Adaptive Idle-Detect Threshold Tuner

This block keeps two idle-detect thresholds, one for the integer execution pipeline and one for the floating-point pipeline. Each pipeline's power-gate controller waits that many idle cycles before it switches the pipeline off. Each controller also pulses a critical-wakeup line when the pipeline has to wake up at the very moment a forced-off window ends. Such a wakeup is a sign that gating is costing performance. The tuner counts these pulses per pipeline over a fixed epoch of cycles.

When an epoch closes, a pipeline whose count is above a threshold has its idle-detect value raised by one. The threshold is a parameter. Every fourth epoch both values are also lowered by one, so the tuner raises quickly and backs off slowly. The values always stay inside a fixed window, and the two pipelines never influence each other. The outputs are plain levels that the gate controllers read directly. All pins are control signals, so there is no valid/ready handshake and no back-pressure.

Top module: `idle_tune_top`

## Requirements
- R1: After reset, both idle-detect outputs equal the lower bound IDLE_MIN (default 5).
- R2: When an epoch closes and a pipeline's critical-wakeup count for that epoch is greater than CRIT_THRESH (default 8), and that epoch is not a decrement epoch, that pipeline's value rises by exactly one.
- R3: A count equal to CRIT_THRESH does not raise the value.
- R4: Each pipeline's value depends only on its own critical-wakeup input.
- R5: Epochs are numbered from 0 after reset. When epoch number k with k mod DEC_EPOCHS equal to DEC_EPOCHS-1 closes (default 3, 7, 11, ...), a pipeline without a raise drops by one.
- R6: When a raise and a decrement fall on the same epoch close, the value is left unchanged.
- R7: A value never rises above IDLE_MAX (default 10). A raise at the upper bound keeps it there.
- R8: A value never falls below IDLE_MIN. A decrement at the lower bound keeps it there.
- R9: An epoch lasts EPOCH_LEN cycles (default 1000), counted from the first clock edge after reset. A pulse in any cycle of an epoch, including its last cycle, counts toward that epoch only. Counts restart from zero in the next epoch.
- R10: The outputs change only on the clock edge that closes an epoch, and by at most one per change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_wake_int_i | input | 1 | Critical-wakeup pulse from the integer pipeline gate controller, one per cycle |
| crit_wake_fp_i | input | 1 | Critical-wakeup pulse from the floating-point pipeline gate controller |
| idle_int_o | output | IDW (4) | Current idle-detect threshold for the integer pipeline |
| idle_fp_o | output | IDW (4) | Current idle-detect threshold for the floating-point pipeline |

## Verification
The tuner is driven with epochs whose pulse count is exactly at the threshold, one above it, far above it, and one pulse in every cycle. These patterns separate an off-by-one compare from a correct one and show that the saturating counter still raises only once. Pulses are placed either at the start or the end of an epoch. This shows that a pulse in the final cycle still counts, and that two sub-threshold halves in neighbouring epochs do not add up. The two pipelines receive different patterns in the same epoch, and raises are timed to meet decrement epochs and both bounds, which exposes cross-talk, a missing cancel and a missing clamp.

// File: rtl/idle_tune_pkg.sv
`timescale 1ns/1ps
package idle_tune_pkg;
  localparam int NUM_PIPES = 2;
  localparam int PIPE_INT  = 0;
  localparam int PIPE_FP   = 1;

  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;
endpackage

// File: rtl/idle_tune_epoch.sv
`timescale 1ns/1ps
module idle_tune_epoch #(
  parameter int EPOCH_LEN  = 1000,
  parameter int DEC_EPOCHS = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_end_o,
  output logic dec_due_o
);
  localparam int EW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
  localparam int DW = (DEC_EPOCHS > 1) ? $clog2(DEC_EPOCHS) : 1;
  localparam logic [EW-1:0] CYC_LAST = EW'(EPOCH_LEN - 1);
  localparam logic [DW-1:0] EP_LAST  = DW'(DEC_EPOCHS - 1);

  logic [EW-1:0] cyc_q;
  logic [DW-1:0] ep_q;

  assign epoch_end_o = (cyc_q == CYC_LAST);
  assign dec_due_o   = epoch_end_o && (ep_q == EP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ep_q  <= '0;
    end else if (epoch_end_o) begin
      cyc_q <= '0;
      ep_q  <= (ep_q == EP_LAST) ? '0 : ep_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/idle_tune_lane.sv
`timescale 1ns/1ps
module idle_tune_lane
  import idle_tune_pkg::*;
#(
  parameter int IDLE_MIN    = 5,
  parameter int IDLE_MAX    = 10,
  parameter int CRIT_THRESH = 8,
  parameter int IDW         = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wake_i,
  input  logic           epoch_end_i,
  input  logic           dec_due_i,
  output logic [IDW-1:0] idle_o
);
  localparam int CAP = CRIT_THRESH + 1;
  localparam int CW  = $clog2(CAP + 1);
  localparam logic [CW-1:0]  CNT_CAP = CW'(CAP);
  localparam logic [CW-1:0]  CNT_THR = CW'(CRIT_THRESH);
  localparam logic [IDW-1:0] V_MIN   = IDW'(IDLE_MIN);
  localparam logic [IDW-1:0] V_MAX   = IDW'(IDLE_MAX);

  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_with_now;
  logic [IDW-1:0] idle_q;
  logic [IDW-1:0] idle_d;
  logic           over;
  adj_e           act;

  // Count including the current cycle's pulse, saturating just above threshold.
  assign cnt_with_now = (wake_i && cnt_q != CNT_CAP) ? cnt_q + 1'b1 : cnt_q;
  assign over         = cnt_with_now > CNT_THR;

  always_comb begin
    act = ADJ_HOLD;
    if (epoch_end_i) begin
      if (over && !dec_due_i)      act = ADJ_UP;
      else if (dec_due_i && !over) act = ADJ_DOWN;
    end
  end

  always_comb begin
    unique case (act)
      ADJ_UP:   idle_d = (idle_q >= V_MAX) ? V_MAX : idle_q + 1'b1;
      ADJ_DOWN: idle_d = (idle_q <= V_MIN) ? V_MIN : idle_q - 1'b1;
      default:  idle_d = idle_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= V_MIN;
    end else begin
      cnt_q  <= epoch_end_i ? '0 : cnt_with_now;
      idle_q <= idle_d;
    end
  end

  assign idle_o = idle_q;
endmodule

// File: rtl/idle_tune_top.sv
`timescale 1ns/1ps
module idle_tune_top
  import idle_tune_pkg::*;
#(
  parameter int EPOCH_LEN   = 1000,
  parameter int DEC_EPOCHS  = 4,
  parameter int IDLE_MIN    = 5,
  parameter int IDLE_MAX    = 10,
  parameter int CRIT_THRESH = 8,
  localparam int IDW        = $clog2(IDLE_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           crit_wake_int_i,
  input  logic           crit_wake_fp_i,
  output logic [IDW-1:0] idle_int_o,
  output logic [IDW-1:0] idle_fp_o
);
  logic                 ep_last;
  logic                 ep_dec;
  logic [NUM_PIPES-1:0] wake_vec;
  logic [IDW-1:0]       idle_arr [NUM_PIPES];

  assign wake_vec[PIPE_INT] = crit_wake_int_i;
  assign wake_vec[PIPE_FP]  = crit_wake_fp_i;

  idle_tune_epoch #(
    .EPOCH_LEN (EPOCH_LEN),
    .DEC_EPOCHS(DEC_EPOCHS)
  ) epoch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .epoch_end_o(ep_last),
    .dec_due_o  (ep_dec)
  );

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_lane
    idle_tune_lane #(
      .IDLE_MIN   (IDLE_MIN),
      .IDLE_MAX   (IDLE_MAX),
      .CRIT_THRESH(CRIT_THRESH),
      .IDW        (IDW)
    ) lane_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_i     (wake_vec[g]),
      .epoch_end_i(ep_last),
      .dec_due_i  (ep_dec),
      .idle_o     (idle_arr[g])
    );
  end

  assign idle_int_o = idle_arr[PIPE_INT];
  assign idle_fp_o  = idle_arr[PIPE_FP];
endmodule

// File: rtl/idle_tune_chk.sv
`timescale 1ns/1ps
module idle_tune_chk #(
  parameter int IDLE_MIN = 5,
  parameter int IDLE_MAX = 10,
  parameter int IDW      = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ep_last,
  input logic           ep_dec,
  input logic [IDW-1:0] idle_int,
  input logic [IDW-1:0] idle_fp
);
  logic rst_seen_q;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst_n;
    // R1
    if (rst_n && !rst_seen_q) begin
      reset_min_chk: assert (idle_int == IDW'(IDLE_MIN) && idle_fp == IDW'(IDLE_MIN));
    end
  end

  // R7
  upper_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_int <= IDW'(IDLE_MAX) && idle_fp <= IDW'(IDLE_MAX));
  // R8
  lower_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_int >= IDW'(IDLE_MIN) && idle_fp >= IDW'(IDLE_MIN));
  // R10
  only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ep_last) |-> ($stable(idle_int) && $stable(idle_fp)));
  // R10
  unit_step_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_int <= $past(idle_int) + 1'b1) && (idle_int + 1'b1 >= $past(idle_int)));
  // R10
  unit_step_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_fp <= $past(idle_fp) + 1'b1) && (idle_fp + 1'b1 >= $past(idle_fp)));
  // R6
  no_rise_on_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ep_dec) |-> (idle_int <= $past(idle_int) && idle_fp <= $past(idle_fp)));
endmodule

bind idle_tune_top idle_tune_chk #(
  .IDLE_MIN(IDLE_MIN),
  .IDLE_MAX(IDLE_MAX),
  .IDW     (IDW)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ep_last (ep_last),
  .ep_dec  (ep_dec),
  .idle_int(idle_int_o),
  .idle_fp (idle_fp_o)
);

// File: tb/idle_tune_top_tb_top.sv
`timescale 1ns/1ps
module idle_tune_top_tb_top;
  localparam int EPOCH = 1000;
  localparam int DECN  = 4;
  localparam int VMIN  = 5;
  localparam int VMAX  = 10;
  localparam int THR   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wi = 1'b0;
  logic       wf = 1'b0;
  logic [3:0] idle_int;
  logic [3:0] idle_fp;

  int n_checks = 0;
  int n_fail = 0;
  int ep = 0;
  int exp_int = VMIN;
  int exp_fp = VMIN;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idle_tune_top dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .crit_wake_int_i(wi),
    .crit_wake_fp_i (wf),
    .idle_int_o     (idle_int),
    .idle_fp_o      (idle_fp)
  );

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (epoch %0d)", req, act, expv, ep);
    end
  endtask

  function automatic int step(input int v, input int n);
    bit up = n > THR;
    bit dn = (ep % DECN) == DECN - 1;
    if (up && !dn) return (v >= VMAX) ? VMAX : v + 1;
    if (dn && !up) return (v <= VMIN) ? VMIN : v - 1;
    return v;
  endfunction

  // Runs one epoch starting at a negedge; pulses placed at start or end.
  task automatic run_epoch(input int ni, input int nf, input bit at_end, input string req);
    for (int i = 0; i < EPOCH; i++) begin
      wi = at_end ? (i >= EPOCH - ni) : (i < ni);
      wf = at_end ? (i >= EPOCH - nf) : (i < nf);
      if (i == EPOCH / 2) begin
        check("R10 mid-epoch int", idle_int, exp_int);
        check("R10 mid-epoch fp", idle_fp, exp_fp);
      end
      @(posedge clk);
      @(negedge clk);
    end
    wi = 1'b0;
    wf = 1'b0;
    exp_int = step(exp_int, ni);
    exp_fp  = step(exp_fp, nf);
    check({req, " int"}, idle_int, exp_int);
    check({req, " fp"}, idle_fp, exp_fp);
    ep++;
  endtask

  task automatic t_reset;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset int", idle_int, VMIN);
    check("R1 reset fp", idle_fp, VMIN);
    rst_n = 1'b1;
  endtask

  task automatic t_raise_and_equal;
    run_epoch(9, 0, 1'b0, "R2 R4 one above threshold");   // 6,5
    check("R4 int isolated", idle_int, 6);
    run_epoch(8, 9, 1'b0, "R3 R4 equal vs above");        // 6,6
    check("R3 equal no raise", idle_int, 6);
    run_epoch(20, 9, 1'b0, "R2 far above");               // 7,7
    check("R2 raise by one", idle_int, 7);
  endtask

  task automatic t_cancel;
    run_epoch(0, 9, 1'b0, "R5 R6 decrement epoch");       // 6,7
    check("R5 decrement int", idle_int, 6);
    check("R6 cancel fp", idle_fp, 7);
  endtask

  task automatic t_clear_and_last_cycle;
    run_epoch(5, 5, 1'b1, "R9 tail half");                // 6,7
    run_epoch(5, 5, 1'b0, "R9 no carry over");            // 6,7
    check("R9 counts cleared", idle_int, 6);
    run_epoch(9, 0, 1'b1, "R9 last-cycle pulse counts");  // 7,7
    check("R9 last cycle", idle_int, 7);
    run_epoch(0, 0, 1'b0, "R5 quiet decrement");          // 6,6
  endtask

  task automatic t_bounds;
    run_epoch(EPOCH, 0, 1'b0, "R2 every cycle");          // 7,6
    check("R2 saturating count raises once", idle_int, 7);
    run_epoch(9, 0, 1'b0, "R2 climb");                    // 8,6
    run_epoch(9, 0, 1'b0, "R2 climb");                    // 9,6
    run_epoch(9, 0, 1'b0, "R6 cancel at decrement");      // 9,5
    check("R6 cancel int", idle_int, 9);
    run_epoch(9, 0, 1'b0, "R2 reach max");                // 10,5
    run_epoch(9, 0, 1'b0, "R7 at max");                   // 10,5
    check("R7 clamp high", idle_int, VMAX);
    run_epoch(9, 0, 1'b0, "R7 at max");                   // 10,5
    run_epoch(0, 0, 1'b0, "R8 decrement at min");         // 9,5
    check("R8 clamp low", idle_fp, VMIN);
    for (int k = 0; k < 4; k++) run_epoch(0, 0, 1'b0, "R5 R8 idle epochs");  // 8,5
    check("R5 slow decay", idle_int, 8);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_raise_and_equal();
    t_cancel();
    t_clear_and_last_cycle();
    t_bounds();
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule